// File: doc/BRIEF.md
# Trace Capture FIFO

The block watches an on-chip trace port once per system clock: a 32-bit data bus and a single control line. Each sample is tested against the capture rule. Samples that qualify go into an eight-deep FIFO. All other samples are thrown away. Software or a DMA channel empties the FIFO through a small register window. The window holds a control/status word and a read port that pops one entry on each read.

On the stream side, the trace input has no back-pressure. The source cannot be stalled, so there is no ready signal toward it. A qualifying sample that meets a full FIFO is lost, and this loss is recorded in a sticky flag. The register side is always ready: an access presented with `bus_valid` high completes in that same cycle. Read data is valid combinationally during the access cycle, and a pop takes effect at the closing clock edge. `dma_req` stays high while entries are waiting and capture is enabled.

A flush bit holds the FIFO empty. This bit is set at reset. Software clears it to start a capture session and sets it again to end one.

Top module: `trace_capture_fifo`

## Requirements
- R1: The FIFO stores up to 8 entries. Each entry is the full 32-bit data bus exactly as sampled, and entries are returned in arrival order.
- R2: A sample taken at a rising clock edge while `trace_ctl` is 0 is pushed.
- R3: A sample taken while `trace_ctl` is 1 is pushed only when `trace_data[1:0]` is 2'b00. All other samples taken with `trace_ctl` at 1 are discarded.
- R4: A qualifying sample that arrives while the FIFO holds 8 entries, with no pop in the same cycle, is dropped and sets the overflow flag (CSR bit 1).
- R5: The overflow flag is sticky. A CSR write with bit 1 equal to 1 clears it, and a CSR write with bit 1 equal to 0 leaves it unchanged.
- R6: The flush bit (CSR bit 0) resets to 1. While it is 1, the FIFO is emptied and held empty, no sample is stored, and the overflow flag cannot be set.
- R7: A read at offset 0x0 returns the flush bit in bit 0, the overflow flag in bit 1, and 0 in all other bits. A write at 0x0 loads the flush bit from write-data bit 0.
- R8: A read at offset 0x4 returns the oldest entry and removes it.
- R9: A read at offset 0x4 while the FIFO is empty returns 0 and leaves the FIFO unchanged.
- R10: When the FIFO is full and a qualifying sample and a 0x4 read occur in the same cycle, the read returns the oldest entry, the sample is stored, and the overflow flag is not set.
- R11: `dma_req` is 1 exactly when the FIFO is non-empty and the flush bit is 0.
- R12: Writes to 0x4 or to any unmapped offset change nothing. Reads at unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; trace is sampled on each rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| trace_ctl | input | 1 | Trace port control line |
| trace_data | input | 32 | Trace port data bus |
| bus_valid | input | 1 | Register access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during the access cycle |
| dma_req | output | 1 | Request to a DMA channel to drain the FIFO |

## Verification
The assertions assume that reset is applied before any access. They also assume that `bus_valid`, `bus_write`, `bus_addr` and the trace inputs are known and steady around each rising edge. To satisfy this, the stimulus changes every input only on the falling clock edge. It presents each register access for exactly one cycle and uses only the offsets 0x0, 0x4 and one unmapped offset. During idle cycles the trace inputs are held at a non-qualifying value (`trace_ctl` high with low data bits 2'b11), so that nothing is captured unless a scenario intends it.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  localparam int unsigned OFS_CTRL = 0;
  localparam int unsigned OFS_POP  = 4;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_POP  = 2'd1,
    SEL_NONE = 2'd2
  } reg_sel_e;

  typedef struct packed {
    logic overflow;
    logic flush;
  } ctrl_bits_t;
endpackage

// File: rtl/tcap_qualify.sv
module tcap_qualify #(
  parameter int unsigned TRIG_W = 2
) (
  input  logic              trace_ctl,
  input  logic [TRIG_W-1:0] trace_low,
  output logic              keep
);
  // Data cycle when control is low; trigger marker when control is high
  // and the low data bits are all zero.
  always_comb begin
    keep = !trace_ctl || (trace_low == '0);
  end
endmodule

// File: rtl/tcap_fifo.sv
module tcap_fifo #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] head,
  output logic              empty,
  output logic              full,
  output logic              drop
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count;
  logic              pop_ok, push_ok;

  always_comb begin
    empty   = (count == '0);
    full    = (count == CNT_W'(DEPTH));
    pop_ok  = pop && !empty;
    push_ok = push && (!full || pop_ok);
    drop    = push && full && !pop_ok;
    head    = mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (push_ok && !clear) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      unique case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R1
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> empty); // R6
  AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push && !clear) |=> empty); // R9
  AST_FULL_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && full && !clear) |=> full); // R10
endmodule

// File: rtl/tcap_regs.sv
module tcap_regs
  import tcap_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_head,
  input  logic              fifo_drop,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              fifo_pop,
  output logic              flush
);
  reg_sel_e   sel;
  ctrl_bits_t ctrl_q;
  logic       wr_ctrl;
  logic       unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:2];

  always_comb begin
    if (bus_addr == ADDR_W'(OFS_CTRL))     sel = SEL_CTRL;
    else if (bus_addr == ADDR_W'(OFS_POP)) sel = SEL_POP;
    else                                   sel = SEL_NONE;
  end

  always_comb begin
    wr_ctrl  = bus_valid && bus_write && (sel == SEL_CTRL);
    fifo_pop = bus_valid && !bus_write && (sel == SEL_POP);
    flush    = ctrl_q.flush;
  end

  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      SEL_CTRL: bus_rdata = {{(DATA_W-2){1'b0}}, ctrl_q};
      SEL_POP:  bus_rdata = fifo_empty ? '0 : fifo_head;
      default:  bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q.flush    <= 1'b1;
      ctrl_q.overflow <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q.flush <= bus_wdata[0];
      if (fifo_drop)                     ctrl_q.overflow <= 1'b1;
      else if (wr_ctrl && bus_wdata[1])  ctrl_q.overflow <= 1'b0;
    end
  end

  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_drop |=> ctrl_q.overflow); // R4
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.overflow && !(wr_ctrl && bus_wdata[1])) |=> ctrl_q.overflow); // R5
  AST_NO_DROP_IN_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.flush |-> !fifo_drop); // R6
endmodule

// File: rtl/trace_capture_fifo.sv
module trace_capture_fifo #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned TRIG_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trace_ctl,
  input  logic [DATA_W-1:0] trace_data,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              dma_req
);
  logic              keep, flush, push, pop;
  logic              empty, full, drop;
  logic [DATA_W-1:0] head;

  tcap_qualify #(.TRIG_W(TRIG_W)) u_qual (
    .trace_ctl (trace_ctl),
    .trace_low (trace_data[TRIG_W-1:0]),
    .keep      (keep)
  );

  assign push = keep && !flush;

  tcap_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (flush),
    .push    (push),
    .pop     (pop),
    .wr_data (trace_data),
    .head    (head),
    .empty   (empty),
    .full    (full),
    .drop    (drop)
  );

  tcap_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .fifo_empty (empty),
    .fifo_head  (head),
    .fifo_drop  (drop),
    .bus_rdata  (bus_rdata),
    .fifo_pop   (pop),
    .flush      (flush)
  );

  assign dma_req = !empty && !flush;

  AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> dma_req || flush); // R11
endmodule

// File: tb/trace_capture_fifo_test.sv
`timescale 1ns/1ps
module trace_capture_fifo_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trace_ctl = 1'b1;
  logic [31:0] trace_data = 32'h3;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        dma_req;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  trace_capture_fifo uut (
    .clk(clk), .rst_n(rst_n), .trace_ctl(trace_ctl), .trace_data(trace_data),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dma_req(dma_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_word(input logic ctl, input logic [31:0] d);
    @(negedge clk);
    trace_ctl = ctl; trace_data = d;
    @(negedge clk);
    trace_ctl = 1'b1; trace_data = 32'h3;
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R11 dma_req after reset", {31'b0, dma_req}, 32'h0);
    bus_rd(4'h0, d); check("R6/R7 ctrl after reset", d, 32'h1);
    bus_rd(4'h4, d); check("R9 pop after reset", d, 32'h0);
  endtask

  task automatic t_flush_blocks();
    logic [31:0] d;
    for (int i = 0; i < 10; i++) push_word(1'b0, 32'hF000_0000 + i);
    check("R6 dma_req while flushed", {31'b0, dma_req}, 32'h0);
    bus_rd(4'h0, d); check("R6 no overflow while flushed", d, 32'h1);
    bus_rd(4'h4, d); check("R6 nothing stored while flushed", d, 32'h0);
  endtask

  task automatic t_normal();
    logic [31:0] d;
    bus_wr(4'h0, 32'h0);
    check("R11 dma_req idle empty", {31'b0, dma_req}, 32'h0);
    push_word(1'b0, 32'hA5A5_0001);
    check("R11 dma_req with data", {31'b0, dma_req}, 32'h1);
    push_word(1'b0, 32'h1234_5678);
    push_word(1'b0, 32'hFFFF_FFFF);
    bus_rd(4'h4, d); check("R2/R8 first", d, 32'hA5A5_0001);
    bus_rd(4'h4, d); check("R1 second", d, 32'h1234_5678);
    bus_rd(4'h4, d); check("R1 third full bus", d, 32'hFFFF_FFFF);
    check("R11 dma_req drained", {31'b0, dma_req}, 32'h0);
  endtask

  task automatic t_trigger();
    logic [31:0] d;
    push_word(1'b1, 32'hDEAD_BEE1);
    push_word(1'b1, 32'hDEAD_BEE2);
    push_word(1'b1, 32'hDEAD_BEE3);
    push_word(1'b1, 32'hDEAD_BEEC);
    bus_rd(4'h4, d); check("R3 trigger stored", d, 32'hDEAD_BEEC);
    bus_rd(4'h4, d); check("R3 others discarded", d, 32'h0);
  endtask

  task automatic t_empty_read();
    logic [31:0] d;
    bus_rd(4'h4, d); check("R9 empty read zero", d, 32'h0);
    push_word(1'b0, 32'h0BAD_F00D);
    bus_rd(4'h4, d); check("R9 state intact after empty read", d, 32'h0BAD_F00D);
  endtask

  task automatic t_overflow();
    logic [31:0] d;
    for (int i = 0; i < 9; i++) push_word(1'b0, 32'h1000_0000 + i);
    bus_rd(4'h0, d); check("R4 overflow set", d, 32'h2);
    for (int i = 0; i < 8; i++) begin
      bus_rd(4'h4, d); check("R1/R4 kept entry", d, 32'h1000_0000 + i);
    end
    bus_rd(4'h4, d); check("R4 ninth dropped", d, 32'h0);
    bus_wr(4'h0, 32'h0);
    bus_rd(4'h0, d); check("R5 write 0 keeps flag", d, 32'h2);
    bus_wr(4'h0, 32'h2);
    bus_rd(4'h0, d); check("R5 write 1 clears flag", d, 32'h0);
  endtask

  task automatic t_swap();
    logic [31:0] d;
    for (int i = 0; i < 8; i++) push_word(1'b0, 32'h2000_0000 + i);
    @(negedge clk);
    trace_ctl = 1'b0; trace_data = 32'h2BAD_0008;
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 4'h4;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_valid = 1'b0; trace_ctl = 1'b1; trace_data = 32'h3;
    check("R10 swap read oldest", d, 32'h2000_0000);
    for (int i = 1; i < 8; i++) begin
      bus_rd(4'h4, d); check("R10 remaining", d, 32'h2000_0000 + i);
    end
    bus_rd(4'h4, d); check("R10 pushed sample kept", d, 32'h2BAD_0008);
    bus_rd(4'h0, d); check("R10 no overflow", d, 32'h0);
  endtask

  task automatic t_ignored();
    logic [31:0] d;
    bus_wr(4'h4, 32'hFFFF_FFFF);
    bus_wr(4'h8, 32'h3);
    bus_rd(4'h0, d); check("R12 ctrl unchanged", d, 32'h0);
    bus_rd(4'h4, d); check("R12 fifo still empty", d, 32'h0);
    push_word(1'b0, 32'h5555_AAAA);
    bus_rd(4'h8, d); check("R12 unmapped read zero", d, 32'h0);
    bus_rd(4'h4, d); check("R12 unmapped read no pop", d, 32'h5555_AAAA);
  endtask

  task automatic t_flush_clear();
    logic [31:0] d;
    for (int i = 0; i < 3; i++) push_word(1'b0, 32'h3000_0000 + i);
    check("R11 dma_req before flush", {31'b0, dma_req}, 32'h1);
    bus_wr(4'h0, 32'h1);
    check("R11 dma_req off in flush", {31'b0, dma_req}, 32'h0);
    push_word(1'b0, 32'h3000_00FF);
    bus_rd(4'h0, d); check("R7 ctrl reads flush", d, 32'h1);
    bus_wr(4'h0, 32'h0);
    bus_rd(4'h4, d); check("R6 flush emptied fifo", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_flush_blocks();
    t_normal();
    t_trigger();
    t_empty_read();
    t_overflow();
    t_swap();
    t_ignored();
    t_flush_clear();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule